// File: doc/BRIEF.md
# Four-Channel Prescaled Down-Counter Timer

The block holds four independent decrementing counters behind a simple synchronous register bus. Each channel is configured through a control byte that enables it, chooses the counting width (16 or 32 bits), picks a prescale divisor for the shared tick input, and selects how an underflow is handled. It can wrap to all-ones, reload from a queued background value, or stop at zero. The tick input is a count-enable strobe sampled on each clock edge.

A background reload value can be written at any time without disturbing the running count; it is picked up at the channel's next underflow. Every underflow latches a per-channel status bit. A shared mask decides which status bits drive the single interrupt output. Status bits are cleared by writing ones.

Reads are combinational from registered state and writes take effect at the clock edge on which `bus_sel_i` and `bus_wr_i` are both high. Only word-aligned addresses (bits 1:0 zero) are decoded.

Top module: `quad_tick_timer`

## Requirements
- R1: Register layout. Shared registers sit at 0x00 (interrupt mask, read/write), 0x04 (raw status, read-only), 0x08 (masked status, read-only) and 0x0C (clear, write-only, reads 0), with bit n for channel n. Channel n uses 0x10+0x10·n. Its load register is at +0x0 (a write sets both the current value and the background value at once; a read returns the background value), the current value at +0x4, control at +0x8 (bits 5:4 read 0) and background load at +0xC.
- R2: Control bit 7 enables the channel. While it is clear the current value does not change, and the channel's prescale counter is held at zero. The prescale counter is also zeroed by any load write.
- R3: Control bits 3:2 select the prescale divisor: 00 gives one count step per tick, 01 one step per 16 ticks, 10 one step per 256 ticks. 11 behaves as 00. After enabling with divisor 16, the first step comes on the 16th tick.
- R4: Control bit 1 selects 32-bit counting when 1 and 16-bit counting when 0. In 16-bit mode only bits 15:0 count, and the value register reads those bits zero-extended.
- R5: A step when the value is non-zero decrements it by one. A step when the value is zero is an underflow. With bit 6 = 0 and bit 0 = 0 (free-running), an underflow wraps the value to all-ones of the selected width.
- R6: With bit 6 = 1 and bit 0 = 0 (periodic), an underflow reloads the value from the background register. A background write leaves the current count untouched.
- R7: With bit 0 = 1 (one-shot, which takes precedence over bit 6), an underflow leaves the value at zero and stops the channel. Nothing further happens until the channel is re-enabled (bit 7 written 1 while it was 0) or reloaded.
- R8: Each underflow sets that channel's raw status bit. Masked status equals raw status AND mask, and `irq_o` is high exactly when masked status is non-zero.
- R9: Writing 1 to a bit of the clear register clears that raw status bit. If an underflow of the same channel happens in the same cycle, the bit stays set.
- R10: Channels are independent: one channel's configuration and underflows do not change another channel's value.
- R11: A load write in a cycle where the channel would otherwise step takes priority. The new value is stored as written and no underflow is raised in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-enable strobe fed to every prescaler |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe (with select) |
| bus_addr_i | input | AW (8) | Byte address |
| bus_wdata_i | input | DW (32) | Write data |
| bus_rdata_o | output | DW (32) | Read data, combinational, zero when not selected |
| irq_o | output | 1 | OR of the masked status bits |

## Verification
Assertions check on every cycle that a disabled channel holds its count and a stopped one-shot channel stays frozen with no further underflow. They also check that a load write wins over a count step, that every underflow lands in raw status, and that a clear without a simultaneous underflow empties the bit. The bench scenarios are needed for the arithmetic that depends on history: how many ticks the divisors consume, where the 16-bit and 32-bit wraps land, and that a queued background value takes effect only at the next underflow. The scenarios also cover prescale restart after disable, the mask-to-interrupt path, and re-arming a finished one-shot.

// File: rtl/qtt_pkg.sv
package qtt_pkg;

    // prescale divisor selector, field bits 3:2 of the control byte
    typedef enum logic [1:0] {
        DIV_1   = 2'b00,
        DIV_16  = 2'b01,
        DIV_256 = 2'b10,
        DIV_RSV = 2'b11
    } div_sel_e;

    // control byte, declared MSB first so that bit positions match the bus
    typedef struct packed {
        logic     en;        // bit 7
        logic     periodic;  // bit 6
        logic [1:0] rsv;     // bits 5:4, always stored as zero
        div_sel_e div;       // bits 3:2
        logic     wide;      // bit 1
        logic     oneshot;   // bit 0
    } ctrl_t;

    localparam int CTRL_W     = $bits(ctrl_t);
    localparam int DIV_A_LOG  = 4;
    localparam int DIV_B_LOG  = 8;

    // word selector inside a 16-byte page
    localparam logic [1:0] W_LOAD  = 2'd0;
    localparam logic [1:0] W_VALUE = 2'd1;
    localparam logic [1:0] W_CTRL  = 2'd2;
    localparam logic [1:0] W_BGLD  = 2'd3;

    localparam logic [1:0] W_MASK  = 2'd0;
    localparam logic [1:0] W_RAW   = 2'd1;
    localparam logic [1:0] W_MIS   = 2'd2;
    localparam logic [1:0] W_CLR   = 2'd3;

endpackage

// File: rtl/qtt_prescale.sv
module qtt_prescale
    import qtt_pkg::*;
#(
    parameter int PRE_W = DIV_B_LOG
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     clr_i,
    input  logic     tick_i,
    input  div_sel_e div_i,
    output logic     step_o
);

    localparam logic [PRE_W-1:0] LIM_A = PRE_W'((1 << DIV_A_LOG) - 1);
    localparam logic [PRE_W-1:0] LIM_B = PRE_W'((1 << DIV_B_LOG) - 1);

    logic [PRE_W-1:0] cnt_d, cnt_q;
    logic [PRE_W-1:0] lim;
    logic             use_pre;

    always_comb begin
        use_pre = 1'b0;
        lim     = '0;
        case (div_i)
            DIV_16:  begin use_pre = 1'b1; lim = LIM_A; end
            DIV_256: begin use_pre = 1'b1; lim = LIM_B; end
            default: begin use_pre = 1'b0; lim = '0;    end
        endcase

        step_o = tick_i && (!use_pre || (cnt_q == lim));

        cnt_d = cnt_q;
        if (clr_i || !use_pre) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = step_o ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // R2
    pre_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/qtt_channel.sv
module qtt_channel
    import qtt_pkg::*;
#(
    parameter int DW    = 32,
    parameter int PRE_W = DIV_B_LOG
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          ld_we_i,
    input  logic          ctrl_we_i,
    input  logic          bg_we_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] val_o,
    output logic [DW-1:0] bg_o,
    output ctrl_t         ctrl_o,
    output logic          uf_o
);

    localparam int HW = DW / 2;

    typedef struct packed {
        logic [DW-1:0] cur;
        logic [DW-1:0] bg;
        ctrl_t         ctrl;
        logic          done;
    } chan_st_t;

    chan_st_t      st_d, st_q;
    logic [DW-1:0] wmask;
    logic [DW-1:0] cnt;
    logic          pre_step;
    logic          pre_clr;
    logic          step;
    ctrl_t         new_ctrl;

    assign wmask   = st_q.ctrl.wide ? {DW{1'b1}} : {{(DW-HW){1'b0}}, {HW{1'b1}}};
    assign cnt     = st_q.cur & wmask;
    assign pre_clr = !st_q.ctrl.en || ld_we_i;

    qtt_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (pre_clr),
        .tick_i (tick_i),
        .div_i  (st_q.ctrl.div),
        .step_o (pre_step)
    );

    always_comb begin
        new_ctrl     = ctrl_t'(wdata_i[CTRL_W-1:0]);
        new_ctrl.rsv = '0;

        st_d = st_q;
        step = st_q.ctrl.en && !st_q.done && pre_step && !ld_we_i;
        uf_o = step && (cnt == '0);

        if (step) begin
            if (cnt != '0) begin
                st_d.cur = (cnt - 1'b1) & wmask;
            end else if (st_q.ctrl.oneshot) begin
                st_d.cur  = '0;
                st_d.done = 1'b1;
            end else if (st_q.ctrl.periodic) begin
                st_d.cur = st_q.bg & wmask;
            end else begin
                st_d.cur = wmask;
            end
        end

        if (bg_we_i) begin
            st_d.bg = wdata_i;
        end

        if (ld_we_i) begin
            st_d.cur  = wdata_i;
            st_d.bg   = wdata_i;
            st_d.done = 1'b0;
        end

        if (ctrl_we_i) begin
            st_d.ctrl = new_ctrl;
            if (new_ctrl.en && !st_q.ctrl.en) begin
                st_d.done = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign val_o  = cnt;
    assign bg_o   = st_q.bg;
    assign ctrl_o = st_q.ctrl;

    // R2
    off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_q.ctrl.en && !ld_we_i) |=> $stable(st_q.cur));

    // R7
    oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.done && !ld_we_i && !ctrl_we_i) |=> ($stable(st_q.cur) && !uf_o));

    // R11
    load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_we_i |=> (st_q.cur == $past(wdata_i)));

    // R11
    load_no_uf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_we_i |-> !uf_o);

endmodule

// File: rtl/qtt_irq.sv
module qtt_irq #(
    parameter int N_CH = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            mask_we_i,
    input  logic            clr_we_i,
    input  logic [N_CH-1:0] wdata_i,
    input  logic [N_CH-1:0] uf_i,
    output logic [N_CH-1:0] mask_o,
    output logic [N_CH-1:0] raw_o,
    output logic [N_CH-1:0] mis_o,
    output logic            irq_o
);

    typedef struct packed {
        logic [N_CH-1:0] mask;
        logic [N_CH-1:0] raw;
    } irq_st_t;

    irq_st_t         st_d, st_q;
    logic [N_CH-1:0] clr;

    always_comb begin
        clr          = clr_we_i ? wdata_i : '0;
        st_d         = st_q;
        st_d.mask    = mask_we_i ? wdata_i : st_q.mask;
        st_d.raw     = (st_q.raw & ~clr) | uf_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign mask_o = st_q.mask;
    assign raw_o  = st_q.raw;
    assign mis_o  = st_q.raw & st_q.mask;
    assign irq_o  = |mis_o;

    // R8
    uf_sets_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|uf_i) |=> ((st_q.raw & $past(uf_i)) == $past(uf_i)));

    // R9
    clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(clr & ~uf_i)) |=> ((st_q.raw & $past(clr & ~uf_i)) == '0));

endmodule

// File: rtl/quad_tick_timer.sv
module quad_tick_timer
    import qtt_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int DW    = 32,
    parameter int AW    = 8,
    parameter int PRE_W = DIV_B_LOG
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          bus_sel_i,
    input  logic          bus_wr_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [DW-1:0] bus_wdata_i,
    output logic [DW-1:0] bus_rdata_o,
    output logic          irq_o
);

    localparam int PW = AW - 4;

    logic            acc_ok;
    logic            wr_ok;
    logic [PW-1:0]   page;
    logic [1:0]      word;
    logic            shr_hit;

    logic [N_CH-1:0] ld_we, ctrl_we, bg_we, uf;
    logic [DW-1:0]   ch_val [N_CH];
    logic [DW-1:0]   ch_bg  [N_CH];
    ctrl_t           ch_ctl [N_CH];

    logic            mask_we, clr_we;
    logic [N_CH-1:0] mask, raw, mis;

    assign acc_ok  = bus_sel_i && (bus_addr_i[1:0] == 2'b00);
    assign wr_ok   = acc_ok && bus_wr_i;
    assign page    = bus_addr_i[AW-1:4];
    assign word    = bus_addr_i[3:2];
    assign shr_hit = (page == '0);

    assign mask_we = wr_ok && shr_hit && (word == W_MASK);
    assign clr_we  = wr_ok && shr_hit && (word == W_CLR);

    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        logic hit;
        assign hit        = (page == PW'(k + 1));
        assign ld_we[k]   = wr_ok && hit && (word == W_LOAD);
        assign ctrl_we[k] = wr_ok && hit && (word == W_CTRL);
        assign bg_we[k]   = wr_ok && hit && (word == W_BGLD);

        qtt_channel #(.DW(DW), .PRE_W(PRE_W)) u_ch (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .tick_i    (tick_i),
            .ld_we_i   (ld_we[k]),
            .ctrl_we_i (ctrl_we[k]),
            .bg_we_i   (bg_we[k]),
            .wdata_i   (bus_wdata_i),
            .val_o     (ch_val[k]),
            .bg_o      (ch_bg[k]),
            .ctrl_o    (ch_ctl[k]),
            .uf_o      (uf[k])
        );
    end

    qtt_irq #(.N_CH(N_CH)) u_irq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .mask_we_i (mask_we),
        .clr_we_i  (clr_we),
        .wdata_i   (bus_wdata_i[N_CH-1:0]),
        .uf_i      (uf),
        .mask_o    (mask),
        .raw_o     (raw),
        .mis_o     (mis),
        .irq_o     (irq_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (acc_ok) begin
            if (shr_hit) begin
                case (word)
                    W_MASK:  bus_rdata_o = DW'(mask);
                    W_RAW:   bus_rdata_o = DW'(raw);
                    W_MIS:   bus_rdata_o = DW'(mis);
                    default: bus_rdata_o = '0;
                endcase
            end
            for (int k = 0; k < N_CH; k++) begin
                if (page == PW'(k + 1)) begin
                    case (word)
                        W_LOAD:  bus_rdata_o = ch_bg[k];
                        W_VALUE: bus_rdata_o = ch_val[k];
                        W_CTRL:  bus_rdata_o = {{(DW-CTRL_W){1'b0}}, ch_ctl[k]};
                        default: bus_rdata_o = ch_bg[k];
                    endcase
                end
            end
        end
    end

    // R8
    irq_follows_mis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o == |(raw & mask)));

endmodule

// File: tb/tb_quad_tick_timer.sv
module tb_quad_tick_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit fin = 1'b0;

    always #10 clk = ~clk;

    quad_tick_timer dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_i      (tick),
        .bus_sel_i   (sel),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic [7:0]  ctrl;
        logic [31:0] load;
        logic [15:0] wait_n;
        logic [31:0] expv;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{"R5 ", 8'h82, 32'd100,        16'd10,  32'd90},         // div1 32-bit
        '{"R3 ", 8'h86, 32'd100,        16'd32,  32'd98},         // div16
        '{"R3 ", 8'h8A, 32'd5,          16'd300, 32'd4},          // div256
        '{"R3 ", 8'h8E, 32'd50,         16'd7,   32'd43},         // reserved -> div1
        '{"R4 ", 8'h80, 32'h0001_0003,  16'd2,   32'd1},          // 16-bit masking
        '{"R4 ", 8'h80, 32'd2,          16'd4,   32'h0000_FFFE},  // 16-bit wrap
        '{"R5 ", 8'h82, 32'd1,          16'd3,   32'hFFFF_FFFE},  // 32-bit wrap
        '{"R6 ", 8'hC2, 32'd3,          16'd5,   32'd2},          // periodic reload
        '{"R7 ", 8'h83, 32'd2,          16'd10,  32'd0},          // one-shot stop
        '{"R7 ", 8'hC3, 32'd2,          16'd10,  32'd0}           // one-shot over periodic
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // caller is at a negedge; one posedge passes
    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1;
        d = rdata;
        sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] base(input int ch);
        return 8'(8'h10 + 8'h10 * ch);
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd_reg(8'h14, v);  check("R1 reset value", v, 32'd0);
        rd_reg(8'h18, v);  check("R1 reset ctrl", v, 32'd0);
        rd_reg(8'h04, v);  check("R8 reset raw", v, 32'd0);
        check("R8 reset irq", {31'd0, irq}, 32'd0);

        // vector table on channel 0
        for (int i = 0; i < NV; i++) begin
            wr_reg(8'h18, 32'd0);
            wr_reg(8'h10, VECS[i].load);
            wr_reg(8'h18, {24'd0, VECS[i].ctrl});
            idle(int'(VECS[i].wait_n));
            rd_reg(8'h14, v);
            check($sformatf("%s vector %0d", VECS[i].tag, i), v, VECS[i].expv);
        end

        // R6 background load on channel 1
        wr_reg(base(1) + 8, 32'd0);
        wr_reg(base(1),     32'd10);
        wr_reg(base(1) + 8, 32'h0000_00C2);
        idle(2);
        rd_reg(base(1) + 4, v);  check("R6 count before bg write", v, 32'd8);
        wr_reg(base(1) + 12, 32'd4);
        rd_reg(base(1) + 4, v);  check("R6 bg write leaves count", v, 32'd7);
        rd_reg(base(1) + 12, v); check("R1 bg readback", v, 32'd4);
        idle(8);
        rd_reg(base(1) + 4, v);  check("R6 reload from bg", v, 32'd4);
        rd_reg(8'h14, v);        check("R10 ch0 unaffected", v, 32'd0);
        rd_reg(8'h04, v);        check("R8 raw bits 0 and 1", v & 32'h3, 32'h3);
        rd_reg(base(1) + 8, v);  check("R1 ctrl readback", v, 32'h0000_00C2);
        wr_reg(base(1) + 8, 32'd0);
        wr_reg(8'h0C, 32'hF);
        rd_reg(8'h04, v);        check("R9 clear all", v, 32'd0);

        // R7/R8 one-shot and mask on channel 2
        wr_reg(base(2) + 8, 32'd0);
        wr_reg(base(2),     32'd1);
        wr_reg(base(2) + 8, 32'h0000_0083);
        idle(3);
        rd_reg(8'h04, v);        check("R7 one-shot underflow raw", v, 32'h4);
        check("R8 irq masked off", {31'd0, irq}, 32'd0);
        wr_reg(8'h00, 32'h4);
        check("R8 irq on mask", {31'd0, irq}, 32'd1);
        rd_reg(8'h08, v);        check("R8 masked status", v, 32'h4);
        rd_reg(8'h00, v);        check("R1 mask readback", v, 32'h4);
        wr_reg(8'h00, 32'h1);
        check("R8 irq other mask", {31'd0, irq}, 32'd0);
        wr_reg(8'h0C, 32'h4);
        idle(5);
        rd_reg(8'h04, v);        check("R7 no repeat underflow", v, 32'd0);
        rd_reg(base(2) + 4, v);  check("R7 held at zero", v, 32'd0);
        wr_reg(base(2) + 8, 32'h0000_0003);
        wr_reg(base(2) + 8, 32'h0000_0083);
        idle(1);
        rd_reg(8'h04, v);        check("R7 re-enable rearms", v, 32'h4);
        wr_reg(base(2), 32'd3);
        idle(2);
        rd_reg(base(2) + 4, v);  check("R7 reload restarts", v, 32'd1);
        wr_reg(base(2) + 8, 32'd0);
        wr_reg(8'h0C, 32'h4);

        // R9 clear versus simultaneous underflow on channel 3
        wr_reg(base(3) + 8, 32'd0);
        wr_reg(base(3),     32'd0);
        wr_reg(base(3) + 8, 32'h0000_00C2);
        idle(2);
        wr_reg(8'h0C, 32'h8);
        rd_reg(8'h04, v);        check("R9 underflow beats clear", v, 32'h8);
        wr_reg(base(3) + 8, 32'd0);
        wr_reg(8'h0C, 32'h8);
        rd_reg(8'h04, v);        check("R9 clear when idle", v, 32'd0);

        // R2 disable hold and prescale restart on channel 0
        wr_reg(8'h18, 32'd0);
        wr_reg(8'h10, 32'd20);
        wr_reg(8'h18, 32'h0000_0002);
        idle(10);
        rd_reg(8'h14, v);        check("R2 disabled holds", v, 32'd20);
        wr_reg(8'h18, 32'h0000_0086);
        idle(10);
        wr_reg(8'h18, 32'h0000_0006);
        wr_reg(8'h18, 32'h0000_0086);
        idle(10);
        rd_reg(8'h14, v);        check("R2 prescale restarts", v, 32'd20);
        idle(6);
        rd_reg(8'h14, v);        check("R3 first div16 step", v, 32'd19);

        // R11 load during counting
        wr_reg(8'h18, 32'h0000_0082);
        idle(3);
        wr_reg(8'h10, 32'd7);
        rd_reg(8'h14, v);        check("R11 load wins step", v, 32'd7);
        rd_reg(8'h10, v);        check("R1 load offset reads bg", v, 32'd7);
        rd_reg(8'h0C, v);        check("R1 clear reads zero", v, 32'd0);

        fin = 1'b1;
        summary();
        $finish;
    end

endmodule